// File: doc/BRIEF.md
# Dual-Window Bank Mapper

This block translates the 16-bit addresses of an 8-bit CPU into accesses to a larger extended RAM. Two fixed 16 KB windows of the CPU space are each steered by their own bank register. Window 0 spans 0x8000–0xBFFF and window 1 spans 0x4000–0x7FFF. While a bus cycle hits a window, the block asserts the extended-RAM select and drives a 17-bit physical address: the 3-bit bank number of that window above the 14 offset bits, which pass through unchanged. Every other valid cycle goes to base RAM.

The bank numbers sit in a four-entry register file that has one write port and separate read ports. The CPU loads an entry by a bus write to one of the four I/O addresses 0xFE00–0xFE03. Because each window reads its own entry, software can aim one window at one bank and the other window at a second bank. A copy or compare between two banks then needs no reload between accesses. Translation is combinational within the bus cycle. A register write lands on the clock edge that ends the write cycle.

Top module: `dual_window_bank_mapper`

## Requirements
- R1: A synchronous active-low reset clears all four bank entries to 0, so window accesses after reset use bank 0.
- R2: A valid cycle with cpu_addr[15:14] = 2'b10 asserts ext_sel, deasserts base_sel and drives ext_addr[16:14] from entry 0.
- R3: A valid cycle with cpu_addr[15:14] = 2'b01 asserts ext_sel, deasserts base_sel and drives ext_addr[16:14] from entry 1.
- R4: While ext_sel is high, ext_addr[13:0] equals cpu_addr[13:0].
- R5: A valid cycle outside both windows (cpu_addr[15:14] = 2'b00 or 2'b11, the I/O addresses included) asserts base_sel only, and ext_addr is 0.
- R6: With bus_valid low, both selects are low, ext_addr is 0, and no entry is written.
- R7: A valid write cycle with cpu_addr[15:2] = 0xFE00 >> 2 loads entry cpu_addr[1:0] with cpu_data[2:0]. The new value is used from the next cycle on, and cpu_data[7:3] are discarded.
- R8: Entries 2 and 3 accept writes but never steer either window.
- R9: Read cycles to 0xFE00–0xFE03 and write cycles to any other address leave all entries unchanged.
- R10: The two windows keep distinct banks at the same time, so accesses may alternate between them with no reload.
- R11: Window translation is the same for read and write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | The current cycle carries an address |
| bus_write | input | 1 | The current cycle is a write |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| ext_addr | output | 17 | Extended-RAM physical address: bank over 14-bit offset |
| ext_sel | output | 1 | Extended-RAM select |
| base_sel | output | 1 | Base-RAM select |

## Verification
The selects and ext_addr are combinational, so they are due in the same cycle as the address. The bench drives each cycle just after the falling edge and samples a few nanoseconds later, before the next rising edge. A register load appears one cycle after its write cycle, because one flip-flop stage sits on that path. The reference model therefore commits a write only after it has compared that cycle's outputs, and the very next comparison already expects the new bank. This timing is exercised by window accesses placed directly behind each load.

// File: rtl/bankmap_pkg.sv
// Package: shared sizes and window layout for the dual-window bank mapper.
// Assumes a 16-bit CPU space split into four 16 KB pages by the top two bits.
package bankmap_pkg;
    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 8;
    localparam int BANK_W      = 3;
    localparam int NUM_ENTRIES = 4;
    localparam int NUM_WIN     = 2;
    localparam int OFS_W       = 14;
    localparam int SEL_W       = $clog2(NUM_ENTRIES);
    localparam int PAGE_W      = ADDR_W - OFS_W;
    localparam int PHYS_W      = BANK_W + OFS_W;
    localparam logic [ADDR_W-1:0] IO_BASE = 16'hFE00;

    typedef logic [BANK_W-1:0] bank_t;

    // Page code of window w: window 0 at 0x8000, window 1 at 0x4000.
    function automatic logic [PAGE_W-1:0] win_page(input int w);
        return (w == 0) ? 2'b10 : 2'b01;
    endfunction
endpackage

// File: rtl/bank_regfile.sv
// Module: bank_regfile
// Holds NUM_ENTRIES bank numbers. It has one synchronous write port and
// N_RD combinational read ports with independent indices.
// Assumes that at most one write arrives per clock.
module bank_regfile #(
    parameter int NUM_ENTRIES = 4,
    parameter int BANK_W      = 3,
    parameter int N_RD        = 2,
    localparam int SEL_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [SEL_W-1:0]                  wr_idx,
    input  logic [BANK_W-1:0]                 wr_val,
    input  logic [N_RD-1:0][SEL_W-1:0]        rd_idx,
    output logic [N_RD-1:0][BANK_W-1:0]       rd_val
);
    logic [NUM_ENTRIES-1:0][BANK_W-1:0] entries;

    // Storage: clear on reset, otherwise load the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entries <= '0;
        end else if (wr_en) begin
            entries[wr_idx] <= wr_val;
        end
    end

    genvar r;
    generate
        for (r = 0; r < N_RD; r++) begin : g_rd
            // Read port r: an unregistered select of the addressed entry.
            always_comb rd_val[r] = entries[rd_idx[r]];
        end
    endgenerate
endmodule

// File: rtl/window_decoder.sv
// Module: window_decoder
// Flags which window, if any, the current valid cycle hits.
// Assumes the windows occupy distinct pages, so the hit vector is one-hot or zero.
module window_decoder
    import bankmap_pkg::*;
#(
    parameter int N_WIN = NUM_WIN
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_WIN-1:0]  hit,
    output logic              any_hit
);
    genvar w;
    generate
        for (w = 0; w < N_WIN; w++) begin : g_win
            localparam logic [PAGE_W-1:0] PAGE = win_page(w);
            // Window w comparator: page field against the window's code.
            always_comb hit[w] = valid && (addr[ADDR_W-1 -: PAGE_W] == PAGE);
        end
    endgenerate

    // Summary flag: the cycle goes to extended RAM.
    always_comb any_hit = |hit;
endmodule

// File: rtl/io_write_decoder.sv
// Module: io_write_decoder
// Turns a bus write in the bank-register I/O range into a register-file write.
// Assumes the range is NUM_ENTRIES words aligned at IO_BASE.
module io_write_decoder
    import bankmap_pkg::*;
(
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] data_lo,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_idx,
    output logic [BANK_W-1:0] wr_val
);
    // Range match: every address bit above the entry index must equal IO_BASE.
    always_comb wr_en = valid && write &&
                        (addr[ADDR_W-1:SEL_W] == IO_BASE[ADDR_W-1:SEL_W]);

    // Entry index and value: low address bits and low data bits.
    always_comb begin
        wr_idx = addr[SEL_W-1:0];
        wr_val = data_lo;
    end
endmodule

// File: rtl/bank_out_mux.sv
// Module: bank_out_mux
// Builds the physical address and the two RAM selects from the window hits.
// Assumes the hit vector is one-hot or zero and is already qualified by valid.
module bank_out_mux
    import bankmap_pkg::*;
#(
    parameter int N_WIN = NUM_WIN
) (
    input  logic                         valid,
    input  logic [N_WIN-1:0]             hit,
    input  logic [N_WIN-1:0][BANK_W-1:0] win_bank,
    input  logic [OFS_W-1:0]             offset,
    output logic [PHYS_W-1:0]            phys,
    output logic                         ext_sel,
    output logic                         base_sel
);
    bank_t chosen;

    // Bank select: AND-OR of the bank of each hit window.
    always_comb begin
        chosen = '0;
        for (int w = 0; w < N_WIN; w++) begin
            if (hit[w]) chosen = chosen | win_bank[w];
        end
    end

    // Outputs: drive the address only while extended RAM is selected.
    always_comb begin
        ext_sel  = |hit;
        base_sel = valid && !(|hit);
        phys     = ext_sel ? {chosen, offset} : '0;
    end
endmodule

// File: rtl/dual_window_bank_mapper.sv
// Module: dual_window_bank_mapper (top)
// Maps two 16 KB CPU windows into extended RAM. Each window uses its own
// bank register, which software loads by I/O writes at IO_BASE.
// Assumes one bus cycle per clock. Outputs are combinational from the
// address; a register load takes effect on the following cycle.
module dual_window_bank_mapper
    import bankmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    output logic [16:0]       ext_addr,
    output logic              ext_sel,
    output logic              base_sel
);
    logic                         wr_en;
    logic [SEL_W-1:0]             wr_idx;
    bank_t                        wr_val;
    logic [NUM_WIN-1:0][SEL_W-1:0]  rd_idx;
    logic [NUM_WIN-1:0][BANK_W-1:0] win_bank;
    logic [NUM_WIN-1:0]           hit;
    logic                         any_hit;
    logic                         unused_data_hi;

    // The high data bits carry nothing for a 3-bit bank.
    always_comb unused_data_hi = ^cpu_data[DATA_W-1:BANK_W];

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_idx
            // Fixed binding: window w reads entry w.
            always_comb rd_idx[w] = SEL_W'(w);
        end
    endgenerate

    io_write_decoder u_iodec (
        .valid   (bus_valid),
        .write   (bus_write),
        .addr    (cpu_addr),
        .data_lo (cpu_data[BANK_W-1:0]),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_val  (wr_val)
    );

    bank_regfile #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .BANK_W      (BANK_W),
        .N_RD        (NUM_WIN)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_val (wr_val),
        .rd_idx (rd_idx),
        .rd_val (win_bank)
    );

    window_decoder #(.N_WIN(NUM_WIN)) u_wdec (
        .valid   (bus_valid),
        .addr    (cpu_addr),
        .hit     (hit),
        .any_hit (any_hit)
    );

    bank_out_mux #(.N_WIN(NUM_WIN)) u_mux (
        .valid    (bus_valid),
        .hit      (hit),
        .win_bank (win_bank),
        .offset   (cpu_addr[OFS_W-1:0]),
        .phys     (ext_addr),
        .ext_sel  (ext_sel),
        .base_sel (base_sel)
    );

    logic unused_any_hit;
    // The summary flag is unused here; the mux derives its own select.
    always_comb unused_any_hit = any_hit;
endmodule

// File: rtl/bankmap_checker.sv
// Module: bankmap_checker
// Temporal properties at the mapper's ports. It is attached with bind.
module bankmap_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic [16:0] ext_addr,
    input logic        ext_sel,
    input logic        base_sel
);
    // R2
    a_r2_win0_selects: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && cpu_addr[15:14] == 2'b10) |-> (ext_sel && !base_sel));
    // R3
    a_r3_win1_selects: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && cpu_addr[15:14] == 2'b01) |-> (ext_sel && !base_sel));
    // R4
    a_r4_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel |-> (ext_addr[13:0] == cpu_addr[13:0]));
    // R5
    a_r5_outside_base: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && cpu_addr[15] == cpu_addr[14]) |-> (base_sel && !ext_sel && ext_addr == 17'h0));
    // R6
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (!ext_sel && !base_sel && ext_addr == 17'h0));
    // R7: a load of entry 0 steers window 0 on the next cycle.
    a_r7_load_win0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && cpu_addr == 16'hFE00) |=>
        (!(bus_valid && cpu_addr[15:14] == 2'b10) || ext_addr[16:14] == $past(cpu_data[2:0])));
    // R7: a load of entry 1 steers window 1 on the next cycle.
    a_r7_load_win1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && cpu_addr == 16'hFE01) |=>
        (!(bus_valid && cpu_addr[15:14] == 2'b01) || ext_addr[16:14] == $past(cpu_data[2:0])));
endmodule

bind dual_window_bank_mapper bankmap_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .cpu_addr  (cpu_addr),
    .cpu_data  (cpu_data),
    .ext_addr  (ext_addr),
    .ext_sel   (ext_sel),
    .base_sel  (base_sel)
);

// File: tb/tb_dual_window_bank_mapper.sv
module tb_dual_window_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_write;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic [16:0] ext_addr;
    logic        ext_sel, base_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int model_bank [4];

    always #10 clk = ~clk;   // 50 MHz

    dual_window_bank_mapper dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .ext_addr(ext_addr), .ext_sel(ext_sel), .base_sel(base_sel)
    );

    // One bus cycle: drive after the falling edge, compare with the model,
    // then commit any register write the model would see at the rising edge.
    task automatic cyc(input bit v, input bit w, input logic [15:0] a,
                       input logic [7:0] d, input string tag);
        int  exp_addr;
        bit  exp_ext, exp_base;
        @(negedge clk);
        bus_valid = v; bus_write = w; cpu_addr = a; cpu_data = d;
        #3;
        exp_ext = 0; exp_base = 0; exp_addr = 0;
        if (v) begin
            if (a[15:14] == 2'b10) begin
                exp_ext = 1; exp_addr = model_bank[0] * 16384 + a[13:0];
            end else if (a[15:14] == 2'b01) begin
                exp_ext = 1; exp_addr = model_bank[1] * 16384 + a[13:0];
            end else begin
                exp_base = 1;
            end
        end
        checks++;
        if (ext_sel !== exp_ext || base_sel !== exp_base || int'(ext_addr) != exp_addr
            || $isunknown(ext_addr)) begin
            fails++;
            $display("FAIL %s: addr=%h got ext_sel=%b base_sel=%b ext_addr=%h exp ext_sel=%b base_sel=%b ext_addr=%h",
                     tag, a, ext_sel, base_sel, ext_addr, exp_ext, exp_base, exp_addr[16:0]);
        end
        if (rst_n && v && w && a[15:2] == 14'h3F80)
            model_bank[a[1:0]] = int'(d[2:0]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_valid = 0; bus_write = 0; cpu_addr = '0; cpu_data = '0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) model_bank[i] = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst_n = 1'b0; bus_valid = 0; bus_write = 0; cpu_addr = '0; cpu_data = '0;
        do_reset();
        // R1: both windows start on bank 0
        cyc(1, 0, 16'h8123, 8'h00, "R1 R2 reset bank win0");
        cyc(1, 0, 16'h4ABC, 8'h00, "R1 R3 reset bank win1");
        // R7: loads with junk high data bits, used on the very next cycle
        cyc(1, 1, 16'hFE00, 8'hFD, "R7 R5 load entry0");
        cyc(1, 0, 16'hBFFF, 8'h00, "R7 R2 R4 next-cycle win0");
        cyc(1, 1, 16'hFE01, 8'hA3, "R7 load entry1");
        cyc(1, 0, 16'h4000, 8'h00, "R7 R3 R4 next-cycle win1");
        // R10: alternate windows with no reload
        for (int i = 0; i < 6; i++)
            cyc(1, 0, (i % 2) ? 16'h7000 + i : 16'h9000 + i, 8'h00, "R10 alternate windows");
        // R11: writes into windows translate like reads
        cyc(1, 1, 16'h8001, 8'h55, "R11 R2 write win0");
        cyc(1, 1, 16'h7FFE, 8'hAA, "R11 R3 write win1");
        // R8: entries 2 and 3 never steer a window
        cyc(1, 1, 16'hFE02, 8'h07, "R8 load entry2");
        cyc(1, 1, 16'hFE03, 8'h06, "R8 load entry3");
        cyc(1, 0, 16'hA000, 8'h00, "R8 win0 unchanged");
        cyc(1, 0, 16'h5000, 8'h00, "R8 win1 unchanged");
        // R9: out-of-range writes and in-range reads change nothing
        cyc(1, 1, 16'hFE04, 8'h02, "R9 write FE04");
        cyc(1, 1, 16'hFDFC, 8'h02, "R9 write FDFC");
        cyc(1, 1, 16'h7E00, 8'h02, "R9 write 7E00");
        cyc(1, 0, 16'hFE00, 8'h02, "R9 read FE00");
        cyc(1, 0, 16'h8000, 8'h00, "R9 win0 unchanged");
        cyc(1, 0, 16'h4000, 8'h00, "R9 win1 unchanged");
        // R6: idle cycles, including an idle write to the I/O range
        cyc(0, 1, 16'hFE00, 8'h01, "R6 idle write");
        cyc(0, 0, 16'h8000, 8'h00, "R6 idle window addr");
        cyc(1, 0, 16'h8000, 8'h00, "R6 idle write ignored");
        // R5: base-RAM addresses at the page edges
        cyc(1, 0, 16'h0000, 8'h00, "R5 base 0000");
        cyc(1, 0, 16'h3FFF, 8'h00, "R5 base 3FFF");
        cyc(1, 0, 16'hC000, 8'h00, "R5 base C000");
        cyc(1, 1, 16'hFFFF, 8'h00, "R5 base FFFF");
        // Mixed traffic, frequently hitting the I/O range (R2 R3 R4 R5 R7 R10)
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = (lfsr[2:0] == 3'd0) ? {14'h3F80, lfsr[9:8]} : {lfsr[15:4], lfsr[3:0] ^ 4'h5};
            cyc(lfsr[11] | lfsr[6], lfsr[7], a, lfsr[15:8], "R2 R3 R4 R5 R7 mixed");
        end
        // R1: a second reset returns both windows to bank 0
        cyc(1, 1, 16'hFE00, 8'h04, "R7 pre-reset load");
        cyc(1, 1, 16'hFE01, 8'h05, "R7 pre-reset load");
        do_reset();
        cyc(1, 0, 16'h8888, 8'h00, "R1 win0 after reset");
        cyc(1, 0, 16'h4444, 8'h00, "R1 win1 after reset");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule